// File: doc/BRIEF.md
# Dual-Line Four-Channel Serial Audio Receiver

This block receives two I2S serial data lines that share one bit clock and one word-select line. The front line carries the front stereo pair and the rear line carries the rear stereo pair. Both lines are shifted in on the same rising edges of the bit clock. Both follow the same word-select timing, so every left or right slot yields one word from each line at the same moment.

The block runs directly on the bit clock, which must be continuous. Each slot keeps the first 18 bits, most significant bit first. When a right slot ends, the block releases all four words together as one frame: front-left, front-right, rear-left and rear-right. A single-cycle strobe marks the new frame. Downstream logic on the bit-clock domain captures the four words on the strobe. The words then stay steady until the next frame.

Top module: `quad_i2s_rx`

## Requirements
- R1: A synchronous active-high reset clears all four output words to zero and holds the frame strobe low.
- R2: Word select low selects the left channel and high selects the right channel. The front line feeds the front-left and front-right outputs, and the rear line feeds the rear-left and rear-right outputs.
- R3: Data is sampled on the rising edge of the bit clock, most significant bit first. The first bit of a word is the one sampled one bit period after the edge where word select is first seen at its new level. The last bit of a word is sampled on that transition edge itself.
- R4: In a slot longer than 18 bits, the bits after the 18th have no effect on the output word.
- R5: In a slot shorter than 18 bits, the received bits fill the most significant positions and the missing least significant bits read as zero.
- R6: The strobe is high for exactly one cycle. It rises after the rising edge on which word select is first seen low after a right slot. All four words change on that same edge.
- R7: After reset, no frame is released until a left slot that began after reset has been fully received and followed by its right slot. A partial slot at start-up is discarded.
- R8: While the strobe is low, all four output words hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock, continuous, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ws | input | 1 | Word select: 0 left slot, 1 right slot |
| sd_front | input | 1 | Serial data of the front pair |
| sd_rear | input | 1 | Serial data of the rear pair |
| fl_word | output | 18 | Front-left sample |
| fr_word | output | 18 | Front-right sample |
| rl_word | output | 18 | Rear-left sample |
| rr_word | output | 18 | Rear-right sample |
| frame_valid | output | 1 | One-cycle strobe marking a new frame |

## Verification
The bench builds the block with its default word width of 18 bits. This sets where truncation and padding begin. The slot length is a bench setting rather than a design parameter, so 16-, 18-, 20- and 32-bit slots and randomly chosen lengths from 10 to 40 bits are all reachable at this width. They exercise padding, exact fit and discarded trailing bits. Resets are applied with word select both high and low. The start-up partial slot is therefore discarded for either channel.

// File: rtl/quad_i2s_pkg.sv
package quad_i2s_pkg;
  // Timing events shared by the slot controller and the data lanes.
  typedef struct packed {
    logic word_end;   // current edge samples the last bit of a slot
    logic end_right;  // the slot that ends is a right-channel slot
    logic publish;    // a complete left/right frame ends on this edge
  } slot_evt_t;
endpackage

// File: rtl/qi2s_slot_ctrl.sv
module qi2s_slot_ctrl
  import quad_i2s_pkg::*;
#(
  parameter int WORD_W = 18,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ws,
  output logic [CNT_W-1:0] bit_idx,
  output logic             bit_en,
  output slot_evt_t        evt
);
  logic ws_d;
  logic in_sync;
  logic left_ok;
  logic ws_edge;

  assign ws_edge       = ws ^ ws_d;
  assign bit_en        = (bit_idx < CNT_W'(WORD_W));
  assign evt.word_end  = ws_edge;
  assign evt.end_right = ws_d;
  assign evt.publish   = ws_edge && ws_d && left_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_d    <= 1'b0;
      bit_idx <= '0;
      in_sync <= 1'b0;
      left_ok <= 1'b0;
    end else begin
      ws_d <= ws;
      if (ws_edge) begin
        bit_idx <= '0;
        in_sync <= 1'b1;
        left_ok <= ws_d ? 1'b0 : in_sync;
      end else if (bit_en) begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  // R6: a frame only closes when word select has just gone from right to left.
  p_publish_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    evt.publish |-> ($past(ws) == 1'b1 && ws == 1'b0));

  // R4: the bit position never runs past the word width.
  p_idx_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    bit_idx <= CNT_W'(WORD_W));
endmodule

// File: rtl/qi2s_lane.sv
module qi2s_lane
  import quad_i2s_pkg::*;
#(
  parameter int WORD_W = 18,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sd,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic              bit_en,
  input  slot_evt_t         evt,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word
);
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] acc_next;

  always_comb begin
    acc_next = acc;
    for (int b = 0; b < WORD_W; b++) begin
      if (bit_en && bit_idx == CNT_W'(WORD_W - 1 - b)) acc_next[b] = sd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      left_word <= '0;
    end else if (evt.word_end) begin
      acc <= '0;
      if (!evt.end_right) left_word <= acc_next;
    end else begin
      acc <= acc_next;
    end
  end

  // The right word completes on the closing edge, including its final sample.
  assign right_word = acc_next;

  // R5: a fresh slot starts from an all-zero accumulator.
  p_fresh_slot_r5: assert property (@(posedge clk) disable iff (rst)
    $past(evt.word_end) |-> ((acc & ~acc_next) == '0));
endmodule

// File: rtl/quad_i2s_rx.sv
module quad_i2s_rx
  import quad_i2s_pkg::*;
#(
  parameter int WORD_W = 18,
  localparam int NUM_LINES = 2,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ws,
  input  logic              sd_front,
  input  logic              sd_rear,
  output logic [WORD_W-1:0] fl_word,
  output logic [WORD_W-1:0] fr_word,
  output logic [WORD_W-1:0] rl_word,
  output logic [WORD_W-1:0] rr_word,
  output logic              frame_valid
);
  logic [CNT_W-1:0]  bit_idx;
  logic              bit_en;
  slot_evt_t         evt;
  logic [NUM_LINES-1:0] sd_bus;
  logic [WORD_W-1:0] left_w  [NUM_LINES];
  logic [WORD_W-1:0] right_w [NUM_LINES];

  assign sd_bus = {sd_rear, sd_front};

  qi2s_slot_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ws      (ws),
    .bit_idx (bit_idx),
    .bit_en  (bit_en),
    .evt     (evt)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
    qi2s_lane #(.WORD_W(WORD_W)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .sd         (sd_bus[g]),
      .bit_idx    (bit_idx),
      .bit_en     (bit_en),
      .evt        (evt),
      .left_word  (left_w[g]),
      .right_word (right_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_word     <= '0;
      fr_word     <= '0;
      rl_word     <= '0;
      rr_word     <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= evt.publish;
      if (evt.publish) begin
        fl_word <= left_w[0];
        fr_word <= right_w[0];
        rl_word <= left_w[1];
        rr_word <= right_w[1];
      end
    end
  end

  // R6: the frame strobe never lasts two cycles.
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  // R8: outputs hold while no frame is being released.
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> ($stable(fl_word) && $stable(fr_word) &&
                      $stable(rl_word) && $stable(rr_word)));

  // R1: the cycle after a reset edge shows cleared outputs.
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (fl_word == '0 && fr_word == '0 && rl_word == '0 &&
                    rr_word == '0 && !frame_valid));
endmodule

// File: tb/quad_i2s_rx_bench.sv
module quad_i2s_rx_bench;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ws = 1'b0;
  logic sd_front = 1'b0;
  logic sd_rear = 1'b0;
  logic [W-1:0] fl_word, fr_word, rl_word, rr_word;
  logic frame_valid;

  quad_i2s_rx #(.WORD_W(W)) u_quad_i2s_rx (
    .clk(clk), .rst(rst), .ws(ws), .sd_front(sd_front), .sd_rear(sd_rear),
    .fl_word(fl_word), .fr_word(fr_word), .rl_word(rl_word), .rr_word(rr_word),
    .frame_valid(frame_valid)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int pulses_seen = 0;
  int pulses_expected = 0;
  logic [4*W-1:0] expq[$];
  logic [4*W-1:0] last_frame = '0;
  logic prev_valid = 1'b0;
  logic last_f = 1'b0, last_r = 1'b0;
  string cur_req = "R3";
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic get_bit(input logic [W-1:0] w, input int k);
    if (k < W) return w[W-1-k];
    return logic'($urandom % 2);
  endfunction

  function automatic logic [W-1:0] expect_word(input logic [W-1:0] w, input int s);
    if (s >= W) return w;
    return (w >> (W - s)) << (W - s);
  endfunction

  // Monitor: sample away from the active edge.
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (frame_valid) begin
        pulses_seen++;
        chk(!prev_valid, "R6 strobe width", {17'd0, prev_valid}, '0);
        if (expq.size() == 0) begin
          chk(1'b0, "R7 unexpected frame", fl_word, '0);
        end else begin
          logic [4*W-1:0] e;
          e = expq.pop_front();
          chk(fl_word == e[4*W-1:3*W], {cur_req, " R2 front-left"},  fl_word, e[4*W-1:3*W]);
          chk(fr_word == e[3*W-1:2*W], {cur_req, " R2 front-right"}, fr_word, e[3*W-1:2*W]);
          chk(rl_word == e[2*W-1:W],   {cur_req, " R2 rear-left"},   rl_word, e[2*W-1:W]);
          chk(rr_word == e[W-1:0],     {cur_req, " R2 rear-right"},  rr_word, e[W-1:0]);
          last_frame = e;
        end
      end
      prev_valid = frame_valid;
    end else begin
      prev_valid = 1'b0;
    end
  end

  task automatic send_slot(input bit ch, input int s,
                           input logic [W-1:0] wf, input logic [W-1:0] wr);
    for (int t = 0; t < s; t++) begin
      @(negedge clk);
      ws = ch;
      sd_front = (t == 0) ? last_f : get_bit(wf, t - 1);
      sd_rear  = (t == 0) ? last_r : get_bit(wr, t - 1);
    end
    last_f = get_bit(wf, s - 1);
    last_r = get_bit(wr, s - 1);
  endtask

  task automatic send_frame(input int s, input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [W-1:0] c, input logic [W-1:0] d, input bit exp);
    send_slot(1'b0, s, a, c);
    send_slot(1'b1, s, b, d);
    if (exp) begin
      expq.push_back({expect_word(a, s), expect_word(b, s),
                      expect_word(c, s), expect_word(d, s)});
      pulses_expected++;
    end
  endtask

  task automatic rand_frames(input int n, input int s_fixed);
    for (int i = 0; i < n; i++) begin
      int s;
      s = (s_fixed > 0) ? s_fixed : 10 + int'($urandom % 31);
      send_frame(s, W'($urandom), W'($urandom), W'($urandom), W'($urandom), 1'b1);
    end
  endtask

  task automatic do_reset(input bit ws_level);
    @(negedge clk);
    rst = 1'b1;
    ws = ws_level;
    repeat (3) @(negedge clk);
    chk(fl_word == '0 && fr_word == '0 && rl_word == '0 && rr_word == '0,
        "R1 words cleared", fl_word | fr_word | rl_word | rr_word, '0);
    chk(!frame_valid, "R1 strobe low", {17'd0, frame_valid}, '0);
    expq.delete();
    last_f = 1'b0;
    last_r = 1'b0;
    rst = 1'b0;
  endtask

  task automatic tail_and_hold(input string req);
    send_slot(1'b0, 24, W'($urandom), W'($urandom));
    chk(expq.size() == 0, "R6 all frames released", W'(expq.size()), '0);
    chk(fl_word == last_frame[4*W-1:3*W] && fr_word == last_frame[3*W-1:2*W] &&
        rl_word == last_frame[2*W-1:W] && rr_word == last_frame[W-1:0],
        req, fl_word, last_frame[4*W-1:3*W]);
  endtask

  initial begin
    void'($urandom(32'h5eed_1a2b));
    do_reset(1'b1);

    // Partial right slot after reset is discarded (R7).
    cur_req = "R7";
    send_slot(1'b1, 5, W'($urandom), W'($urandom));
    cur_req = "R3";
    send_frame(18, 18'h2AAAA, 18'h15555, 18'h3FFFF, 18'h00001, 1'b1);
    send_frame(18, 18'h20000, 18'h00001, 18'h1F0F0, 18'h0F0F0, 1'b1);
    rand_frames(10, 18);
    tail_and_hold("R8 hold after stream");

    // Reset with word select low: partial left, then a lone right slot.
    do_reset(1'b0);
    cur_req = "R7";
    send_slot(1'b0, 7, W'($urandom), W'($urandom));
    send_slot(1'b1, 18, W'($urandom), W'($urandom));
    chk(pulses_seen == pulses_expected, "R7 no frame from partial start",
        W'(pulses_seen), W'(pulses_expected));
    send_frame(18, 18'h12345, 18'h2BCDE, 18'h00FFF, 18'h3F000, 1'b1);

    cur_req = "R4";
    send_frame(32, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 1'b1);
    rand_frames(10, 32);
    cur_req = "R5";
    send_frame(16, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 1'b1);
    rand_frames(10, 16);
    cur_req = "R4";
    rand_frames(8, 20);
    cur_req = "R5";
    rand_frames(20, 0);
    tail_and_hold("R8 hold after mixed lengths");

    chk(pulses_seen == pulses_expected, "R6 frame count",
        W'(pulses_seen), W'(pulses_expected));
    done = 1;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
  end

  initial begin
    wait (done || $time >= 8 * 150000);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule